// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a byte-addressable non-volatile store that answers as a target on a two-wire serial bus. It watches already-sampled clock and data lines, recognises bus START and STOP conditions, and checks the device address it is sent against two strap inputs. Up to four copies can therefore sit on one bus. After its address it takes a two-byte word address. Data bytes that follow are collected in a one-page staging buffer, and that buffer is copied into the array when the controller ends the transaction. Reads return bytes from a running pointer for as long as the controller keeps acknowledging.

The protocol pointer is always 15 bits wide, so it spans 0x0000 to 0x7FFF and holds 512 pages of 64 bytes each. The implemented array depth is the parameter `MEM_AW`: 11 gives the default of 2 KiB, and 15 gives the full 32 KiB. Higher pointer bits alias onto the implemented depth. After a write is committed, the device is busy for `WR_CYC` clock cycles, which stands in for the real programming time. The only output is an open-drain pull-low enable for the data line.

Top module: `ee_serial_target`

## Requirements
- R1: A START (data falling while the bus clock is high) begins a new frame from any state, including a repeated START inside a transaction. A STOP (data rising while the bus clock is high) ends the transaction.
- R2: The first byte after START holds the 7-bit address 1010 0 S1 S0 in bits 7..1, with S1 S0 taken from `dev_sel_i[1:0]`, and the direction flag in bit 0 (1 = read). On a match the device pulls data low through the ninth clock. On a mismatch it never pulls data low and ignores all traffic until the next START.
- R3: In a write, the byte after the address byte sets pointer bits 14..8 from its low 7 bits, and its bit 7 is ignored. The next byte sets pointer bits 7..0. Each of these bytes is acknowledged.
- R4: Each data byte of a write is acknowledged and staged. At STOP the staged bytes are written into the array.
- R5: During a write, only pointer bits 5..0 advance, rolling from 63 back to 0 inside the same 64-byte page. Bytes outside that page are never touched.
- R6: While `wr_lock_i` is high at STOP, the array is left unchanged and no busy period starts. Data bytes are still acknowledged.
- R7: For `WR_CYC` cycles after a committed STOP, the device does not acknowledge its own address.
- R8: A read returns the byte at the pointer and then increments all 15 pointer bits, wrapping from 0x7FFF to 0x0000, on every byte. It continues while the controller acknowledges, and a read without a preceding address continues from where the pointer stopped.
- R9: A write that carries only the two address bytes, followed by a repeated START and a read, reads from the new address. It causes no array write and no busy period.
- R10: Read data leaves MSB first and changes only while the bus clock is low. After the controller's no-acknowledge, the device releases the data line.
- R11: Reset releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired level) |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| dev_sel_i | input | 2 | Address straps S1 S0 |
| wr_lock_i | input | 1 | 1 = writes into the array are inhibited |

## Verification
The assertions assume a well-formed controller. Data changes only while the bus clock is low, except at START and STOP. Each bus clock level lasts several system cycles, so every edge is seen once and the pull output settles before the clock goes high again. Under those assumptions the pull line may change only while the clock is low. The bench's controller tasks keep to this: each bus clock half period lasts ten system cycles, data is set up in the low phase, and START and STOP are issued only while the clock is high with the data line released by the device.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int PTR_W = 15;
  localparam int PG_W  = 6;

  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_AHI, PH_ALO, PH_WR, PH_RD} phase_t;

  function automatic logic dev_match(input logic [7:0] b, input logic [1:0] sel);
    return b[7:1] == {4'b1010, 1'b0, sel};
  endfunction

  function automatic logic [PTR_W-1:0] page_step(input logic [PTR_W-1:0] p);
    return {p[PTR_W-1:PG_W], p[PG_W-1:0] + 1'b1};
  endfunction

  function automatic logic [PTR_W-1:0] seq_step(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction
endpackage

// File: rtl/ee_line_monitor.sv
module ee_line_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i; sda_q <= sda_i;
      scl_p <= scl_q; sda_p <= sda_q;
    end
  end

  assign scl_lvl_o  = scl_q;
  assign sda_lvl_o  = sda_q;
  assign scl_rise_o = scl_q & ~scl_p;
  assign scl_fall_o = ~scl_q & scl_p;
  assign start_o    = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_o     = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/ee_bus_ctrl.sv
module ee_bus_ctrl
  import ee_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        dev_sel_i,
  input  logic              wr_lock_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_pull_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              buf_we_o,
  output logic [PG_W-1:0]   buf_idx_o,
  output logic [7:0]        buf_data_o,
  output logic              buf_clear_o,
  output logic              commit_go_o
);
  phase_t           phase;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, rbyte;
  logic [PTR_W-1:0] ptr;
  logic             rnw, mack, wseen;
  logic             dev_hit, byte_end, ack_end;

  assign dev_hit  = dev_match(shreg, dev_sel_i) && !busy_i;
  assign byte_end = scl_fall_i && (bitcnt == 4'd8);
  assign ack_end  = scl_fall_i && (bitcnt == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitcnt <= '0; shreg <= '0; rbyte <= '0;
      ptr <= '0; rnw <= 1'b0; mack <= 1'b0; wseen <= 1'b0; sda_pull_o <= 1'b0;
    end else if (start_i) begin
      phase <= PH_DEV; bitcnt <= '0; sda_pull_o <= 1'b0; wseen <= 1'b0;
    end else if (stop_i) begin
      phase <= PH_IDLE; bitcnt <= '0; sda_pull_o <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise_i) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_lvl_i};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          mack   <= !sda_lvl_i;
          bitcnt <= 4'd9;
        end
      end else if (byte_end) begin
        case (phase)
          PH_DEV: if (dev_hit) begin
                    sda_pull_o <= 1'b1; rnw <= shreg[0];
                  end else begin
                    phase <= PH_IDLE; bitcnt <= '0;
                  end
          PH_AHI: begin ptr[14:8] <= shreg[6:0]; sda_pull_o <= 1'b1; end
          PH_ALO: begin ptr[7:0] <= shreg; sda_pull_o <= 1'b1; end
          PH_WR:  begin ptr <= page_step(ptr); sda_pull_o <= 1'b1; wseen <= 1'b1; end
          default: sda_pull_o <= 1'b0;
        endcase
      end else if (ack_end) begin
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
        case (phase)
          PH_DEV: if (rnw) begin
                    phase <= PH_RD; rbyte <= rd_data_i;
                    ptr <= seq_step(ptr); sda_pull_o <= !rd_data_i[7];
                  end else begin
                    phase <= PH_AHI;
                  end
          PH_AHI: phase <= PH_ALO;
          PH_ALO: phase <= PH_WR;
          PH_RD:  if (mack) begin
                    rbyte <= rd_data_i;
                    ptr <= seq_step(ptr); sda_pull_o <= !rd_data_i[7];
                  end else begin
                    phase <= PH_IDLE;
                  end
          default: ;
        endcase
      end else if (scl_fall_i && phase == PH_RD && bitcnt != 4'd0) begin
        sda_pull_o <= !rbyte[3'd7 - bitcnt[2:0]];
      end
    end
  end

  assign mem_addr_o  = ptr[MEM_AW-1:0];
  assign buf_we_o    = byte_end && (phase == PH_WR);
  assign buf_idx_o   = ptr[PG_W-1:0];
  assign buf_data_o  = shreg;
  assign buf_clear_o = start_i;
  assign commit_go_o = stop_i && (phase == PH_WR) && wseen && !wr_lock_i;

  // R1
  start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (phase == PH_DEV && bitcnt == 4'd0 && !sda_pull_o));
  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (phase == PH_IDLE && !sda_pull_o));
  // R2
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEV && byte_end && shreg[7:1] != {4'b1010, 1'b0, dev_sel_i})
    |=> (!sda_pull_o && phase == PH_IDLE));
  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n) bitcnt <= 4'd9);
  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && phase == PH_DEV && byte_end) |=> !sda_pull_o);
  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> $past(!wr_lock_i));
  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_lvl_i);
endmodule

// File: rtl/ee_page_store.sv
module ee_page_store
  import ee_pkg::*;
#(
  parameter int MEM_AW = 11,
  parameter int WR_CYC = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              buf_we_i,
  input  logic [PG_W-1:0]   buf_idx_i,
  input  logic [7:0]        buf_data_i,
  input  logic              buf_clear_i,
  input  logic              commit_go_i,
  output logic              busy_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PG_W;
  localparam int CNT_W = $clog2(WR_CYC + 1);
  localparam int PGN_W = MEM_AW - PG_W;

  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pval;
  logic [CNT_W-1:0]  bcnt;
  logic [PG_W:0]     cidx;
  logic [PGN_W-1:0]  page_r;
  logic              mem_we;
  logic [MEM_AW-1:0] waddr;

  assign busy_o = (bcnt != '0);
  assign mem_we = busy_o && !cidx[PG_W] && pval[cidx[PG_W-1:0]];
  assign waddr  = {page_r, cidx[PG_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pval <= '0; bcnt <= '0; cidx <= '0; page_r <= '0;
    end else begin
      if (commit_go_i) begin
        bcnt   <= CNT_W'(WR_CYC);
        cidx   <= '0;
        page_r <= rd_addr_i[MEM_AW-1:PG_W];
      end else if (busy_o) begin
        bcnt <= bcnt - 1'b1;
        if (!cidx[PG_W]) cidx <= cidx + 1'b1;
        if (bcnt == CNT_W'(1)) pval <= '0;
      end else if (buf_clear_i) begin
        pval <= '0;
      end
      if (buf_we_i) pval[buf_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we_i) pbuf[buf_idx_i] <= buf_data_i;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[waddr] <= pbuf[cidx[PG_W-1:0]];
  end

  assign rd_data_o = mem[rd_addr_i];

  // R4
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go_i |-> !busy_o);
  // R5
  stage_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !buf_we_i);
endmodule

// File: rtl/ee_serial_target.sv
module ee_serial_target
  import ee_pkg::*;
#(
  parameter int MEM_AW = 11,
  parameter int WR_CYC = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] dev_sel_i,
  input  logic       wr_lock_i
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, buf_we, buf_clear, commit_go;
  logic [7:0] rd_data, buf_data;
  logic [PG_W-1:0] buf_idx;
  logic [MEM_AW-1:0] mem_addr;

  ee_line_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_ev), .stop_o(stop_ev)
  );

  ee_bus_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_lvl_i(scl_lvl), .sda_lvl_i(sda_lvl),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_ev), .stop_i(stop_ev),
    .dev_sel_i(dev_sel_i), .wr_lock_i(wr_lock_i), .busy_i(busy), .rd_data_i(rd_data),
    .sda_pull_o(sda_pull_o), .mem_addr_o(mem_addr), .buf_we_o(buf_we),
    .buf_idx_o(buf_idx), .buf_data_o(buf_data), .buf_clear_o(buf_clear),
    .commit_go_o(commit_go)
  );

  ee_page_store #(.MEM_AW(MEM_AW), .WR_CYC(WR_CYC)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr_i(mem_addr), .rd_data_o(rd_data),
    .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_data_i(buf_data),
    .buf_clear_i(buf_clear), .commit_go_i(commit_go), .busy_o(busy)
  );
endmodule

// File: tb/ee_serial_target_test.sv
module ee_serial_target_test;
  localparam int Q = 10;
  localparam int BUSY_WAIT = 450;
  localparam logic [7:0] WA = 8'hA4;
  localparam logic [7:0] RA = 8'hA5;
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {15'h0010, 8'h5A}, {15'h0123, 8'hC3}, {15'h0240, 8'h77},
    {15'h07FE, 8'h01}, {15'h0555, 8'hFF}, {15'h0000, 8'h3C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_scl = 1'b1, ctl_sda = 1'b1, wr_lock = 1'b0;
  logic sda_pull, bus_sda;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] pdat [16];
  logic [7:0] rbuf [16];

  always #2 clk = ~clk;
  assign bus_sda = ctl_sda & ~sda_pull;

  ee_serial_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(ctl_scl), .sda_i(bus_sda),
    .sda_pull_o(sda_pull), .dev_sel_i(2'b10), .wr_lock_i(wr_lock)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic wh(); repeat (Q/2) @(negedge clk); endtask

  task automatic bstart();
    ctl_sda = 1'b1; wq(); ctl_scl = 1'b1; wq(); ctl_sda = 1'b0; wq(); ctl_scl = 1'b0;
  endtask

  task automatic bstop();
    ctl_sda = 1'b0; wq(); ctl_scl = 1'b1; wq(); ctl_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ak);
    for (int i = 7; i >= 0; i--) begin
      ctl_sda = b[i]; wq(); ctl_scl = 1'b1; wq(); ctl_scl = 1'b0;
    end
    ctl_sda = 1'b1; wq(); ctl_scl = 1'b1; wh(); ak = !bus_sda; wh(); ctl_scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    ctl_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); ctl_scl = 1'b1; wh(); b[i] = bus_sda; wh(); ctl_scl = 1'b0;
    end
    ctl_sda = give_ack ? 1'b0 : 1'b1; wq(); ctl_scl = 1'b1; wq(); ctl_scl = 1'b0;
    ctl_sda = 1'b1;
  endtask

  task automatic write_tx(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
    logic ak; int miss = 0;
    bstart();
    send_byte(WA, ak); if (!ak) miss++;
    send_byte(hi, ak); if (!ak) miss++;
    send_byte(lo, ak); if (!ak) miss++;
    for (int i = 0; i < n; i++) begin send_byte(pdat[i], ak); if (!ak) miss++; end
    bstop();
    chk(req, "missing acks in write", miss, 0);
  endtask

  task automatic read_tx(input logic [7:0] hi, input logic [7:0] lo, input int n);
    logic ak; int miss = 0;
    bstart();
    send_byte(WA, ak); if (!ak) miss++;
    send_byte(hi, ak); if (!ak) miss++;
    send_byte(lo, ak); if (!ak) miss++;
    bstart();
    send_byte(RA, ak); if (!ak) miss++;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    wh();
    chk("R10", "line released after final nack", sda_pull, 1'b0);
    bstop();
    chk("R9", "missing acks in random read", miss, 0);
  endtask

  task automatic cur_read(input int n);
    logic ak;
    bstart();
    send_byte(RA, ak);
    chk("R8", "current read address ack", ak, 1'b1);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    bstop();
  endtask

  task automatic wait_busy(); repeat (BUSY_WAIT) @(negedge clk); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    repeat (5) @(negedge clk);
    chk("R11", "pull during reset", sda_pull, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11", "pull after reset", sda_pull, 1'b0);

    // R4 R8: vector table, byte writes then random reads
    for (int v = 0; v < NV; v++) begin
      pdat[0] = VEC[v][7:0];
      write_tx({1'b0, VEC[v][22:16]}, VEC[v][15:8], 1, "R4");
      wait_busy();
    end
    for (int v = 0; v < NV; v++) begin
      read_tx({1'b0, VEC[v][22:16]}, VEC[v][15:8], 1);
      chk("R4", "byte readback", rbuf[0], VEC[v][7:0]);
    end

    // R6: locked write acked, array unchanged, no busy
    wr_lock = 1'b1;
    pdat[0] = 8'h00;
    write_tx(8'h01, 8'h23, 1, "R6");
    read_tx(8'h01, 8'h23, 1);
    chk("R6", "locked location kept", rbuf[0], 8'hC3);
    wr_lock = 1'b0;

    // R3: bit 7 of high address byte ignored
    pdat[0] = 8'h44;
    write_tx(8'h81, 8'h23, 1, "R3");
    wait_busy();
    read_tx(8'h01, 8'h23, 1);
    chk("R3", "high bit ignored", rbuf[0], 8'h44);

    // R7: busy after commit
    pdat[0] = 8'h66;
    write_tx(8'h05, 8'h55, 1, "R4");
    bstart(); send_byte(WA, ak); bstop();
    chk("R7", "address ack while busy", ak, 1'b0);
    wait_busy();
    bstart(); send_byte(WA, ak); bstop();
    chk("R7", "address ack after busy", ak, 1'b1);
    read_tx(8'h05, 8'h55, 1);
    chk("R4", "readback after busy", rbuf[0], 8'h66);

    // R5: page write from offset 56, 12 bytes wrap within page
    for (int i = 0; i < 12; i++) pdat[i] = 8'h80 + 8'(i);
    write_tx(8'h02, 8'h38, 12, "R5");
    wait_busy();
    read_tx(8'h02, 8'h38, 8);
    for (int i = 0; i < 8; i++) chk("R5", "page tail byte", rbuf[i], 8'h80 + 8'(i));
    cur_read(1);
    chk("R5", "next page untouched (R8 pointer crosses page)", rbuf[0], 8'h77);
    read_tx(8'h02, 8'h00, 4);
    for (int i = 0; i < 4; i++) chk("R5", "page head wrapped byte", rbuf[i], 8'h88 + 8'(i));

    // R2: wrong straps, rest of frame ignored
    begin
      int pulls = 0;
      bstart();
      send_byte(8'hA2, ak); if (ak) pulls++;
      send_byte(8'h00, ak); if (ak) pulls++;
      send_byte(8'h10, ak); if (ak) pulls++;
      send_byte(8'h99, ak); if (ak) pulls++;
      bstop();
      chk("R2", "acks on mismatched address", pulls, 0);
      bstart(); send_byte(8'hAC, ak); bstop();
      chk("R2", "ack on other mismatch", ak, 1'b0);
      read_tx(8'h00, 8'h10, 1);
      chk("R2", "location unchanged after mismatch", rbuf[0], 8'h5A);
    end

    // R8: sequential read wraps 0x7FFF -> 0x0000
    pdat[0] = 8'hE1;
    write_tx(8'h7F, 8'hFF, 1, "R4");
    wait_busy();
    read_tx(8'h7F, 8'hFE, 3);
    chk("R8", "byte at 0x7FFE", rbuf[0], 8'h01);
    chk("R8", "byte at 0x7FFF", rbuf[1], 8'hE1);
    chk("R8", "wrapped byte at 0x0000", rbuf[2], 8'h3C);

    // R9: address-only write leaves no busy period
    bstart(); send_byte(WA, ak); bstop();
    chk("R9", "ack right after random read", ak, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule